// File: doc/BRIEF.md
# Configurable Serial Transmitter

This block sends characters as asynchronous serial frames on a single output line that rests high. The frame shape and the bit rate come from a set of static control inputs. A 16-bit divisor sets the bit rate, and a rate-mode bit chooses between a plain and a halved divisor encoding. A 2-bit length code selects 7, 8 or 9 bit characters. Two further bits turn parity on and choose odd or even. A 2-bit stop code selects one or two stop bits.

A client offers a 9-bit word with a valid/ready handshake. The word is taken only when the transmitter is enabled, the line is idle and the control inputs form a legal setting. Illegal settings raise an error flag and keep the transmitter from starting. A busy output covers the whole frame. A one-cycle done pulse marks the point where the data slot is free again and the line has finished the character. The control inputs are captured when a word is taken, so changes made while a frame is on the line apply only to the next frame.

Top module: `sertx_top`

## Requirements
- R1: After reset and whenever no frame is in progress, `tx_line` is 1 and `busy` is 0. After reset `done` is 0.
- R2: `wlen` selects the character length: 2'b00 gives 8 bits, 2'b01 gives 9 bits and 2'b10 gives 7 bits. 2'b11 is illegal: `cfg_err` is 1, `in_ready` stays 0 and no frame starts.
- R3: A frame is a 0 start bit, then the data bits starting with `in_data[0]`, then the stop bits at 1.
- R4: With `par_en` = 0 all character bits are data. With `par_en` = 1 the last character position carries a parity bit and only the low length-1 data bits are sent. The parity bit makes the count of ones over those data bits plus the parity bit odd when `par_odd` = 1 and even when `par_odd` = 0.
- R5: `stop_sel` 2'b00 gives one stop bit and 2'b10 gives two. 2'b01 and 2'b11 are illegal: `cfg_err` is 1, `in_ready` stays 0 and no frame starts.
- R6: With `over8` = 0 every bit of the frame lasts exactly `div_reg` clock cycles.
- R7: With `over8` = 1 every bit lasts {`div_reg`[15:4], `div_reg`[2:0]} clock cycles, which is ((div & 0xFFF0) | ((div & 7) << 1)) / 2. In this mode `div_reg`[3] = 1 is illegal: `cfg_err` is 1 and no frame starts.
- R8: A `div_reg` value below 16 is illegal: `cfg_err` is 1, `in_ready` stays 0 and no frame starts.
- R9: With `tx_en` = 0, `in_ready` stays 0 and no frame starts, whatever the other inputs are.
- R10: `in_ready` is 1 only when the line is idle, `tx_en` is 1 and the setting is legal. A word is taken on a clock edge where `in_valid` and `in_ready` are both 1. The start bit appears on `tx_line` in the cycle right after that edge, and `busy` rises at the same time.
- R11: When the last stop bit has lasted its full time, `busy` falls and `done` is 1 for exactly one cycle.
- R12: The length, parity, stop and rate settings are captured on the edge where a word is taken. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_en | input | 1 | Transmitter enable |
| div_reg | input | 16 | Bit-rate divisor |
| over8 | input | 1 | Halved-divisor rate mode |
| wlen | input | 2 | Character length code |
| par_en | input | 1 | Parity enable |
| par_odd | input | 1 | Parity sense, 1 = odd |
| stop_sel | input | 2 | Stop bit code |
| in_valid | input | 1 | Data word offered |
| in_data | input | 9 | Data word |
| in_ready | output | 1 | Word can be taken this cycle |
| tx_line | output | 1 | Serial output, idles high |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |
| cfg_err | output | 1 | Current control setting is illegal |

## Verification
The assertions assume the control inputs change only between clock edges and that the captured bit period stays constant for a whole frame. They also assume a word offered during an illegal setting is simply never taken. The stimulus changes settings only at the falling clock edge and keeps every swept divisor legal, at 16 and 19 in the plain mode and at 0x13 and 0x17 in the halved mode. Illegal codes are applied only on purpose, while a word is held offered, so that the bench can watch the line stay idle. Settings are changed in the middle of a frame in only one place, and they are put back before the frame ends.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DATA_W  = 9;
    localparam int DIV_W   = 16;
    localparam int FRAME_W = 1 + DATA_W + 2;
    localparam int LEN_W   = $clog2(FRAME_W + 1);
    localparam int NB_W    = $clog2(DATA_W + 1);

    typedef enum logic [1:0] {
        WL_8   = 2'b00,
        WL_9   = 2'b01,
        WL_7   = 2'b10,
        WL_BAD = 2'b11
    } wlen_e;

    typedef struct packed {
        logic [NB_W-1:0]  nbits;
        logic             par_en;
        logic             par_odd;
        logic             two_stop;
        logic [DIV_W-1:0] period;
    } frame_cfg_t;

    function automatic logic [NB_W-1:0] word_bits(input logic [1:0] code);
        case (wlen_e'(code))
            WL_9:    return NB_W'(9);
            WL_7:    return NB_W'(7);
            default: return NB_W'(8);
        endcase
    endfunction

    // Halved mode drops bit 3 and shifts the upper field down by one.
    function automatic logic [DIV_W-1:0] bit_period(input logic [DIV_W-1:0] dv,
                                                    input logic x8);
        return x8 ? {1'b0, dv[DIV_W-1:4], dv[2:0]} : dv;
    endfunction

    function automatic logic [FRAME_W-1:0] build_frame(input logic [DATA_W-1:0] d,
                                                       input frame_cfg_t c);
        logic [FRAME_W-1:0] f;
        logic [NB_W-1:0]    db;
        logic               p;
        f    = '1;
        f[0] = 1'b0;
        db   = c.nbits - NB_W'(c.par_en);
        p    = c.par_odd;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < int'(db)) begin
                f[1 + i] = d[i];
                p        = p ^ d[i];
            end
        end
        if (c.par_en) f[db + NB_W'(1)] = p;
        return f;
    endfunction

    function automatic logic [LEN_W-1:0] frame_len(input frame_cfg_t c);
        return LEN_W'(c.nbits) + LEN_W'(2) + LEN_W'(c.two_stop);
    endfunction

endpackage

// File: rtl/sertx_cfg_decode.sv
module sertx_cfg_decode
    import sertx_pkg::*;
#(
    parameter int MIN_DIV = 16
) (
    input  logic [DIV_W-1:0] div_reg,
    input  logic             over8,
    input  logic [1:0]       wlen,
    input  logic             par_en,
    input  logic             par_odd,
    input  logic [1:0]       stop_sel,
    output frame_cfg_t       cfg,
    output logic             cfg_bad
);

    logic bad_len, bad_stop, bad_div, bad_x8;

    always_comb begin
        bad_len  = (wlen_e'(wlen) == WL_BAD);
        bad_stop = stop_sel[0];
        bad_div  = (div_reg < DIV_W'(MIN_DIV));
        bad_x8   = over8 && div_reg[3];
        cfg_bad  = bad_len || bad_stop || bad_div || bad_x8;

        cfg.nbits    = word_bits(wlen);
        cfg.par_en   = par_en;
        cfg.par_odd  = par_odd;
        cfg.two_stop = stop_sel[1];
        cfg.period   = bit_period(div_reg, over8);
    end

endmodule

// File: rtl/sertx_baud.sv
module sertx_baud
    import sertx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] period,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == period - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + DIV_W'(1);
    end

    // R6
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < period));

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] data_in,
    input  frame_cfg_t        cfg_in,
    output logic              tx_line,
    output logic              active,
    output logic              done
);

    logic [FRAME_W-1:0] shreg;
    logic [LEN_W-1:0]   left;
    logic [DIV_W-1:0]   period_q;
    logic               tick;

    sertx_baud u_baud (
        .clk    (clk),
        .rst    (rst),
        .run    (active),
        .period (period_q),
        .tick   (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '1;
            left     <= '0;
            period_q <= '0;
            active   <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load && !active) begin
                shreg    <= build_frame(data_in, cfg_in);
                left     <= frame_len(cfg_in);
                period_q <= cfg_in.period;
                active   <= 1'b1;
            end else if (tick) begin
                shreg <= {1'b1, shreg[FRAME_W-1:1]};
                left  <= left - LEN_W'(1);
                if (left == LEN_W'(1)) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    assign tx_line = active ? shreg[0] : 1'b1;

    // R3
    start_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> !tx_line);

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!active && $past(active)));

    // R12
    period_held_chk: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active)) |-> $stable(period_q));

    // R6
    bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active) && !$past(tick)) |-> $stable(shreg));

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic [DIV_W-1:0]  div_reg,
    input  logic              over8,
    input  logic [1:0]        wlen,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [1:0]        stop_sel,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              tx_line,
    output logic              busy,
    output logic              done,
    output logic              cfg_err
);

    frame_cfg_t cfg;
    logic       load;

    sertx_cfg_decode #(.MIN_DIV(16)) u_dec (
        .div_reg  (div_reg),
        .over8    (over8),
        .wlen     (wlen),
        .par_en   (par_en),
        .par_odd  (par_odd),
        .stop_sel (stop_sel),
        .cfg      (cfg),
        .cfg_bad  (cfg_err)
    );

    assign in_ready = tx_en && !cfg_err && !busy;
    assign load     = in_valid && in_ready;

    sertx_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .data_in (in_data),
        .cfg_in  (cfg),
        .tx_line (tx_line),
        .active  (busy),
        .done    (done)
    );

    // R10
    accept_starts_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (busy && !tx_line));

    // R8
    cfg_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(!cfg_err) && $past(tx_en)));

    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> tx_line);

endmodule

// File: tb/test_sertx_top.sv
module test_sertx_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        tx_en;
    logic [15:0] div_reg;
    logic        over8;
    logic [1:0]  wlen;
    logic        par_en;
    logic        par_odd;
    logic [1:0]  stop_sel;
    logic        in_valid;
    logic [8:0]  in_data;
    logic        in_ready, tx_line, busy, done, cfg_err;

    int vectors = 0;
    int miscmp  = 0;

    always #5 clk = ~clk;

    sertx_top i_sertx_top (
        .clk(clk), .rst(rst), .tx_en(tx_en), .div_reg(div_reg), .over8(over8),
        .wlen(wlen), .par_en(par_en), .par_odd(par_odd), .stop_sel(stop_sel),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .tx_line(tx_line), .busy(busy), .done(done), .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscmp++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [8:0] d, input bit scramble);
        int n, db, per, len;
        logic [11:0] fr;
        logic p;
        string rt;
        logic [15:0] s_div; logic s_x8, s_pe, s_po; logic [1:0] s_wl, s_st;
        n   = (wlen == 2'b00) ? 8 : (wlen == 2'b01) ? 9 : 7;
        db  = par_en ? n - 1 : n;
        per = over8 ? ((int'(div_reg) & 32'hFFF0) | ((int'(div_reg) & 7) << 1)) / 2
                    : int'(div_reg);
        len = 1 + n + ((stop_sel == 2'b10) ? 2 : 1);
        rt  = over8 ? "R7" : "R6";
        fr = '1; fr[0] = 1'b0; p = par_odd;
        for (int i = 0; i < db; i++) begin fr[1 + i] = d[i]; p = p ^ d[i]; end
        if (par_en) fr[1 + db] = p;
        s_div = div_reg; s_x8 = over8; s_pe = par_en; s_po = par_odd;
        s_wl = wlen; s_st = stop_sel;

        @(negedge clk); in_data = d; in_valid = 1'b1;
        #1 chk("R10 ready before accept", in_ready, 1);
        @(posedge clk); #1 in_valid = 1'b0;
        chk("R10 busy after accept", busy, 1);
        if (scramble) begin
            wlen = (wlen == 2'b00) ? 2'b10 : 2'b00;
            par_en = ~par_en; par_odd = ~par_odd;
            stop_sel = stop_sel ^ 2'b10;
            div_reg = div_reg + 16'd5;
        end
        repeat (per / 2) @(posedge clk);
        for (int i = 0; i < len; i++) begin
            if (i > 0) repeat (per) @(posedge clk);
            #1;
            if (i == 0)                      chk({"R3 start ", rt}, tx_line, fr[i]);
            else if (i <= db)                chk({"R3 R2 data ", scramble ? "R12" : rt}, tx_line, fr[i]);
            else if (par_en && i == db + 1)  chk({"R4 parity ", scramble ? "R12" : rt}, tx_line, fr[i]);
            else                             chk({"R5 stop ", scramble ? "R12" : rt}, tx_line, 1);
        end
        if (scramble) begin
            div_reg = s_div; over8 = s_x8; par_en = s_pe; par_odd = s_po;
            wlen = s_wl; stop_sel = s_st;
        end
        repeat (per - per / 2 - 1) @(posedge clk);
        #1 chk({"R11 busy in last bit ", rt}, busy, 1);
        chk("R11 no early done", done, 0);
        @(posedge clk); #1;
        chk({"R11 done at frame end ", rt}, done, 1);
        chk("R11 busy cleared", busy, 0);
        chk("R1 idle line", tx_line, 1);
        @(posedge clk); #1;
        chk("R11 done one cycle", done, 0);
    endtask

    task automatic expect_reject(input string req, input logic exp_err);
        @(negedge clk); in_valid = 1'b1; in_data = 9'h155;
        #1 chk({req, " cfg_err"}, cfg_err, exp_err);
        for (int c = 0; c < 24; c++) begin
            @(negedge clk);
            chk({req, " ready held low"}, in_ready, 0);
            chk({req, " no frame"}, busy, 0);
            chk({req, " line idle"}, tx_line, 1);
        end
        in_valid = 1'b0;
    endtask

    task automatic legal_defaults();
        tx_en = 1'b1; div_reg = 16'd16; over8 = 1'b0; wlen = 2'b00;
        par_en = 1'b0; par_odd = 1'b0; stop_sel = 2'b00;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscmp++;
        $display("FAIL R10 watchdog act=running exp=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_data = '0;
        legal_defaults();
        repeat (3) @(posedge clk);
        #1 chk("R1 reset line", tx_line, 1);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset done", done, 0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        chk("R1 idle after reset", tx_line, 1);

        for (int s = 0; s < 4; s++) begin
            over8   = (s >= 2);
            div_reg = (s == 0) ? 16'd16 : (s == 1) ? 16'd19 : (s == 2) ? 16'h13 : 16'h17;
            for (int wl = 0; wl < 3; wl++)
                for (int pm = 0; pm < 3; pm++)
                    for (int st = 0; st < 2; st++)
                        for (int k = 0; k < 2; k++) begin
                            logic [8:0] w;
                            wlen = 2'(wl); par_en = (pm != 0); par_odd = (pm == 2);
                            stop_sel = (st == 1) ? 2'b10 : 2'b00;
                            w = 9'((wl * 61 + pm * 23 + st * 7 + s * 101) ^ 9'h0A5);
                            send_frame(k == 0 ? w : ~w, 1'b0);
                        end
        end

        legal_defaults(); wlen = 2'b11;    expect_reject("R2 length code 11", 1);
        legal_defaults(); stop_sel = 2'b01; expect_reject("R5 stop code 01", 1);
        legal_defaults(); stop_sel = 2'b11; expect_reject("R5 stop code 11", 1);
        legal_defaults(); div_reg = 16'd15; expect_reject("R8 divisor 15", 1);
        legal_defaults(); over8 = 1'b1; div_reg = 16'h18; expect_reject("R7 halved bit3 set", 1);
        legal_defaults(); tx_en = 1'b0;    expect_reject("R9 disabled", 0);

        legal_defaults(); div_reg = 16'd16; wlen = 2'b01; par_en = 1'b1; par_odd = 1'b1;
        stop_sel = 2'b10;
        send_frame(9'h1C3, 1'b1);
        legal_defaults(); wlen = 2'b10;
        send_frame(9'h07F, 1'b1);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

endmodule